// File: doc/BRIEF.md
# Selectable Edge/Level Interrupt Controller

This block collects a vector of per-source interrupt conditions (32 by default) into a status register and one combined interrupt line. One mode bit chooses how conditions are captured. In edge mode, a status bit is captured on a rising edge of its condition. In level mode, a status bit follows an active condition and holds it until software clears it. Software uses a small register port with a write strobe, a two-bit register select and combinational read data. Through it, software sets an enable mask, picks the mode and clears status bits by writing ones.

Where the enable mask acts depends on the mode:

- **Edge mode:** a disabled source never gets its status bit set, and the interrupt line is the OR of all status bits.
- **Level mode:** every active source is recorded in the status register, so masked sources stay visible on readback. The mask only decides which status bits reach the interrupt line.

Because of this split, a status bit set while masked in level mode raises the interrupt line once the mode is switched to edge. That bit can then be cleared, and afterwards its masked source stays quiet.

The mode control is a two-state machine:

| State | Mode |
|-------|------|
| `MODE_EDGE` | edge mode (the reset state) |
| `MODE_LEVEL` | level mode |

Its transitions are:

- `EDGE_TO_LEVEL`: taken on a write of 1 to the mode register.
- `LEVEL_TO_EDGE`: taken on a write of 0 to the mode register.
- A write that repeats the current mode stays in the same state.

Register select values:

| Select | Register |
|--------|----------|
| 0 | status |
| 1 | enable mask |
| 2 | mode, bit 0 |
| 3 | unused |

Top module: `irqc_top`

## Requirements
- R1: While reset is asserted and after it is released, before any stimulus: status, mask and mode all read 0, and `irq_o` is 0.
- R2: In edge mode (mode bit 0), a 0-to-1 change of an enabled condition sets its status bit at the next clock edge. A condition that stays high does not set the bit again after it has been cleared. The rising edge is judged against the condition sampled one clock earlier.
- R3: In edge mode, a condition whose mask bit is 0 never sets its status bit.
- R4: In level mode (mode bit 1), an active condition sets its status bit at the next edge whatever its mask bit is, and the bit reads back as 1 at select 0.
- R5: In level mode, a clear write to a status bit whose condition is still active leaves the bit set. Once the condition is inactive, the same write clears it.
- R6: Writing to select 0 clears each status bit whose data bit is 1. Data bits that are 0 leave their status bits unchanged.
- R7: In level mode, `irq_o` equals the OR of (status AND mask), registered one clock later.
- R8: In edge mode, `irq_o` equals the OR of all status bits, registered one clock later. So a status bit left set while masked in level mode raises `irq_o` after a switch to edge mode.
- R9: If a set event and a clear write of the same status bit fall in the same cycle, the bit ends up set.
- R10: The mask (select 1) and the mode bit (select 2, bit 0) read back what was written, and a new mode applies from the next cycle. Writes to select 3 change nothing, and select 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cond_i | input | N_SRC | Per-source interrupt conditions |
| wr_en | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select for writes and reads |
| wr_data | input | N_SRC | Write data |
| rd_data | output | N_SRC | Combinational read data for `reg_addr` |
| irq_o | output | 1 | Registered combined interrupt |

## Verification
A condition change is sampled at one clock edge. It shows on status readback just after that edge, and reaches `irq_o` one edge later, because the status register and the output register are in series. A register write, a mode change or a mask change acts on status and readback at the edge that takes the write, and on `irq_o` one edge after that. The bench drives and samples 1 ns after each rising edge. A behavioural reference model advances by the same one-edge steps, and both outputs are compared against it on every clock. The directed checks count these one- and two-edge delays explicitly before reading a value.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    typedef enum logic {
        MODE_EDGE  = 1'b0,
        MODE_LEVEL = 1'b1
    } irq_mode_e;

    localparam int unsigned SEL_W = 2;
    localparam logic [SEL_W-1:0] SEL_STATUS = 2'd0;
    localparam logic [SEL_W-1:0] SEL_MASK   = 2'd1;
    localparam logic [SEL_W-1:0] SEL_MODE   = 2'd2;

endpackage

// File: rtl/irqc_mode_fsm.sv
module irqc_mode_fsm
    import irqc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      mode_wr,
    input  logic      mode_val,
    output irq_mode_e mode_q
);

    irq_mode_e state_q;
    irq_mode_e state_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= MODE_EDGE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions EDGE_TO_LEVEL / LEVEL_TO_EDGE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MODE_EDGE: begin
                if (mode_wr && mode_val) begin
                    state_d = MODE_LEVEL;
                end
            end
            MODE_LEVEL: begin
                if (mode_wr && !mode_val) begin
                    state_d = MODE_EDGE;
                end
            end
            default: state_d = MODE_EDGE;
        endcase
    end

    assign mode_q = state_q;

endmodule

// File: rtl/irqc_status_bits.sv
module irqc_status_bits
    import irqc_pkg::*;
#(
    parameter int unsigned N_SRC = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  irq_mode_e        mode,
    input  logic [N_SRC-1:0] cond_i,
    input  logic [N_SRC-1:0] mask,
    input  logic [N_SRC-1:0] clr_vec,
    output logic [N_SRC-1:0] status_q
);

    logic [N_SRC-1:0] cond_prev_q;

    for (genvar i = 0; i < N_SRC; i++) begin : g_bit
        logic set_ev;

        always_comb begin
            if (mode == MODE_LEVEL) begin
                set_ev = cond_i[i];
            end else begin
                set_ev = cond_i[i] & ~cond_prev_q[i] & mask[i];
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cond_prev_q[i] <= 1'b0;
                status_q[i]    <= 1'b0;
            end else begin
                cond_prev_q[i] <= cond_i[i];
                if (set_ev) begin
                    status_q[i] <= 1'b1;          // set wins over clear
                end else if (clr_vec[i]) begin
                    status_q[i] <= 1'b0;
                end
            end
        end
    end

    // edge mode: nothing newly set unless enabled
    assert_edge_mask_gates_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode) == MODE_EDGE) |->
            ((status_q & ~$past(status_q) & ~$past(mask)) == '0));

    // level mode: bits with an active condition cannot be cleared
    assert_level_hold_active_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode) == MODE_LEVEL) |->
            (($past(status_q & cond_i) & ~status_q) == '0));

endmodule

// File: rtl/irqc_irq_out.sv
module irqc_irq_out
    import irqc_pkg::*;
#(
    parameter int unsigned N_SRC = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  irq_mode_e        mode,
    input  logic [N_SRC-1:0] status,
    input  logic [N_SRC-1:0] mask,
    output logic             irq_o
);

    logic irq_d;

    always_comb begin
        unique case (mode)
            MODE_LEVEL: irq_d = |(status & mask);
            MODE_EDGE:  irq_d = |status;
            default:    irq_d = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_o <= 1'b0;
        end else begin
            irq_o <= irq_d;
        end
    end

    assert_level_masked_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode) == MODE_LEVEL && $past((status & mask) == '0)) |-> !irq_o);

    assert_edge_any_status_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode) == MODE_EDGE && $past(status != '0)) |-> irq_o);

endmodule

// File: rtl/irqc_top.sv
module irqc_top
    import irqc_pkg::*;
#(
    parameter int unsigned N_SRC = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N_SRC-1:0]     cond_i,
    input  logic                 wr_en,
    input  logic [SEL_W-1:0]     reg_addr,
    input  logic [N_SRC-1:0]     wr_data,
    output logic [N_SRC-1:0]     rd_data,
    output logic                 irq_o
);

    localparam int unsigned PAD_W = N_SRC - 1;

    logic [N_SRC-1:0] mask_q;
    logic [N_SRC-1:0] status;
    logic [N_SRC-1:0] clr_vec;
    logic             mode_wr;
    irq_mode_e        mode;

    assign mode_wr = wr_en && (reg_addr == SEL_MODE);
    assign clr_vec = (wr_en && (reg_addr == SEL_STATUS)) ? wr_data : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else if (wr_en && (reg_addr == SEL_MASK)) begin
            mask_q <= wr_data;
        end
    end

    irqc_mode_fsm u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_wr  (mode_wr),
        .mode_val (wr_data[0]),
        .mode_q   (mode)
    );

    irqc_status_bits #(.N_SRC(N_SRC)) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (mode),
        .cond_i   (cond_i),
        .mask     (mask_q),
        .clr_vec  (clr_vec),
        .status_q (status)
    );

    irqc_irq_out #(.N_SRC(N_SRC)) u_out (
        .clk    (clk),
        .rst_n  (rst_n),
        .mode   (mode),
        .status (status),
        .mask   (mask_q),
        .irq_o  (irq_o)
    );

    always_comb begin
        unique case (reg_addr)
            SEL_STATUS: rd_data = status;
            SEL_MASK:   rd_data = mask_q;
            SEL_MODE:   rd_data = {{PAD_W{1'b0}}, mode == MODE_LEVEL};
            default:    rd_data = '0;
        endcase
    end

    // a zero data bit never clears its status bit
    assert_w1c_zero_keeps_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_en && reg_addr == SEL_STATUS) |->
            (($past(status & ~wr_data) & ~status) == '0));

endmodule

// File: tb/irqc_top_tb_top.sv
module irqc_top_tb_top;

    localparam int N = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] cond_i = '0;
    logic         wr_en = 1'b0;
    logic [1:0]   reg_addr = 2'd0;
    logic [N-1:0] wr_data = '0;
    logic [N-1:0] rd_data;
    logic         irq_o;

    int checks = 0;
    int errors = 0;

    // reference model state
    logic [N-1:0] m_stat = '0;
    logic [N-1:0] m_mask = '0;
    logic         m_mode = 1'b0;
    logic [N-1:0] m_prev = '0;
    logic         m_irq = 1'b0;

    always #4 clk = ~clk;

    irqc_top #(.N_SRC(N)) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .cond_i   (cond_i),
        .wr_en    (wr_en),
        .reg_addr (reg_addr),
        .wr_data  (wr_data),
        .rd_data  (rd_data),
        .irq_o    (irq_o)
    );

    task automatic check_eq(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [N-1:0] model_rd(input logic [1:0] a);
        case (a)
            2'd0:    return m_stat;
            2'd1:    return m_mask;
            2'd2:    return {{(N-1){1'b0}}, m_mode};
            default: return '0;
        endcase
    endfunction

    // one clock: advance the model, then compare both outputs
    task automatic cyc();
        logic [N-1:0] set_v, clr_v, s_n, k_n, p_n;
        logic         md_n, q_n;
        if (!rst_n) begin
            s_n = '0; k_n = '0; p_n = '0; md_n = 1'b0; q_n = 1'b0;
        end else begin
            set_v = m_mode ? cond_i : (cond_i & ~m_prev & m_mask);
            clr_v = (wr_en && reg_addr == 2'd0) ? wr_data : '0;
            s_n   = set_v | (m_stat & ~clr_v);
            k_n   = (wr_en && reg_addr == 2'd1) ? wr_data : m_mask;
            md_n  = (wr_en && reg_addr == 2'd2) ? wr_data[0] : m_mode;
            q_n   = m_mode ? |(m_stat & m_mask) : |m_stat;
            p_n   = cond_i;
        end
        @(posedge clk);
        #1;
        m_stat = s_n; m_mask = k_n; m_mode = md_n; m_prev = p_n; m_irq = q_n;
        check_eq(m_mode ? "R7 irq" : "R8 irq", {{(N-1){1'b0}}, irq_o}, {{(N-1){1'b0}}, m_irq});
        if (reg_addr == 2'd0) begin
            check_eq(m_mode ? "R4 status" : "R2 status", rd_data, model_rd(reg_addr));
        end else begin
            check_eq("R10 readback", rd_data, model_rd(reg_addr));
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [N-1:0] d);
        reg_addr = a; wr_data = d; wr_en = 1'b1;
        cyc();
        wr_en = 1'b0;
    endtask

    task automatic peek(input string tag, input logic [1:0] a, input logic [N-1:0] exp);
        reg_addr = a;
        #1;
        check_eq(tag, rd_data, exp);
    endtask

    task automatic irq_is(input string tag, input logic exp);
        check_eq(tag, {{(N-1){1'b0}}, irq_o}, {{(N-1){1'b0}}, exp});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) cyc();
        // R1 during reset
        peek("R1 status in reset", 2'd0, '0);
        peek("R1 mask in reset", 2'd1, '0);
        peek("R1 mode in reset", 2'd2, '0);
        irq_is("R1 irq in reset", 1'b0);
        rst_n = 1'b1;
        cyc();
        peek("R1 status after reset", 2'd0, '0);
        irq_is("R1 irq after reset", 1'b0);

        // edge mode
        wr(2'd1, 32'h0000_00FF);
        peek("R10 mask", 2'd1, 32'h0000_00FF);
        cond_i = 32'h0000_0001;
        cyc();
        peek("R2 edge set", 2'd0, 32'h0000_0001);
        irq_is("R8 irq not yet", 1'b0);
        cyc();
        irq_is("R8 irq after status", 1'b1);
        cond_i = 32'h0000_0101;
        cyc(); cyc();
        peek("R3 masked edge", 2'd0, 32'h0000_0001);
        wr(2'd0, 32'h0000_0000);
        peek("R6 zero write", 2'd0, 32'h0000_0001);
        wr(2'd0, 32'h0000_0001);
        peek("R6 one write", 2'd0, 32'h0000_0000);
        cyc();
        peek("R2 steady high no reset", 2'd0, 32'h0000_0000);

        // R9 set beats clear
        cond_i = 32'h0000_0103;
        wr(2'd0, 32'h0000_0002);
        peek("R9 set priority", 2'd0, 32'h0000_0002);
        wr(2'd0, 32'h0000_0002);
        peek("R6 clear bit1", 2'd0, 32'h0000_0000);
        cyc();
        irq_is("R8 irq drops", 1'b0);

        // level mode
        wr(2'd2, 32'h0000_0001);
        peek("R10 mode", 2'd2, 32'h0000_0001);
        cyc();
        peek("R4 level captures masked", 2'd0, 32'h0000_0103);
        cyc();
        irq_is("R7 enabled source", 1'b1);
        cond_i = 32'h0000_0100;
        wr(2'd0, 32'h0000_0103);
        peek("R5 active bit kept", 2'd0, 32'h0000_0100);
        cyc();
        irq_is("R7 masked only", 1'b0);

        // mode switch with masked pending bit
        wr(2'd2, 32'h0000_0000);
        irq_is("R7 before switch", 1'b0);
        cyc();
        irq_is("R8 spurious after switch", 1'b1);
        cond_i = '0;
        wr(2'd0, 32'h0000_0100);
        peek("R5 clear when inactive", 2'd0, '0);
        cyc();
        irq_is("R8 cleared", 1'b0);
        cond_i = 32'h0000_0100;
        cyc(); cyc();
        peek("R3 stays masked", 2'd0, '0);
        irq_is("R3 irq quiet", 1'b0);

        // unused select
        wr(2'd3, 32'hFFFF_FFFF);
        peek("R10 select3 reads zero", 2'd3, '0);
        peek("R10 mask untouched", 2'd1, 32'h0000_00FF);
        peek("R10 mode untouched", 2'd2, '0);

        // random phase against the model
        for (int k = 0; k < 3000; k++) begin
            if ($urandom_range(0, 3) == 0) cond_i = cond_i ^ (32'h1 << $urandom_range(0, N - 1));
            wr_en    = ($urandom_range(0, 4) == 0);
            reg_addr = 2'($urandom_range(0, 3));
            wr_data  = $urandom();
            if (reg_addr == 2'd2) wr_data = {{(N-1){1'b0}}, wr_data[0]};
            cyc();
        end
        wr_en = 1'b0;

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule